// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block decides, for each of two timing-generator channels, which qualified input reference drives that generator, or whether the generator runs in holdover or freerun. Qualification of references is done elsewhere. The block receives a valid bit and a priority value for each reference, plus a flag that says whether holdover history exists. Each channel has its own elector. An elector locks onto the best eligible reference. It keeps that reference until the reference loses eligibility, and when no candidate is left it falls back to holdover or freerun.

A small write-only configuration port selects each channel's mode. The modes are: automatic (follow the elector), manual (a register code picks a reference or forces holdover or freerun), or, on the primary channel only, hard-wired. In hard-wired mode an asynchronous switch pin chooses between two preset codes. In manual mode the secondary channel may also take the primary channel's output as its reference.

Each channel reports its selected index, an operating-state code, the index its elector currently proposes, a one-cycle change strobe, and a flag raised when the channel is locked to a reference that is not valid.

Top module: `ref_select_ctrl`

## Requirements
- R1: In automatic election, a locked reference stays selected while it remains eligible, even when a better candidate appears. The elector re-elects only after the locked reference loses eligibility.
- R2: A reference is eligible when its valid bit is 1 and its priority is nonzero. The elector picks the eligible reference with the smallest priority value, and a tie goes to the lowest index.
- R3: With no eligible reference, the elector state becomes holdover (code 1) if `ho_avail` is 1, and freerun (code 2) if it is 0.
- R4: When a candidate becomes eligible while the elector is in holdover or freerun, the elector returns to locked (code 0) on that candidate. Elector decisions reach the channel outputs two rising edges after the inputs change.
- R5: In automatic mode, a channel's selected index and state equal its elector's. `pri_auto`/`sec_auto` show the elector's index in every mode.
- R6: Configuration writes use `cfg_addr`: 0 = primary mode, 1 = secondary mode, 2 = primary manual code, 3 = secondary manual code, 4 = presets. A mode field `cfg_data[1:0]` of 0 or 3 means automatic, 1 means manual, and 2 means hard-wired. At reset both modes are automatic and both manual codes are freerun.
- R7: A code is `{kind[1:0], index[1:0]}`. Kind 0 locks to the index, kind 1 forces holdover, and kind 2 forces freerun. In manual mode a written code takes effect on the outputs one rising edge after the write edge.
- R8: Kind 3 on the secondary channel gives state 3 (tracking the primary output) with index 0. On the primary channel, kind 3 means freerun.
- R9: In hard-wired mode the primary channel uses the preset code in `cfg_data[3:0]` while `sw_pin` is low and the one in `cfg_data[7:4]` while it is high. The pin goes through two synchronizing flops, so the outputs follow a pin change on the third rising edge. On the secondary channel, mode 2 acts as manual.
- R10: Any change in a channel's selected index or state is marked by its change strobe being 1 for exactly the cycle in which the new values first appear.
- R11: A channel locked to a reference whose valid bit is 0 keeps that selection and raises its invalid flag. The flag clears one edge after the valid bit returns.
- R12: Entering holdover or freerun, whether by election or by a forced code, keeps the previously selected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | NREF | Per-reference qualified flag |
| ref_prio | input | NREF*PW | Per-reference priority, reference i in bits [i*PW +: PW] |
| ho_avail | input | 1 | Holdover history available |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_data | input | 8 | Configuration write data |
| sw_pin | input | 1 | Asynchronous hard-wired switch pin |
| pri_sel | output | IDXW | Primary selected reference index |
| pri_state | output | 2 | Primary state: 0 locked, 1 holdover, 2 freerun |
| pri_auto | output | IDXW | Primary elector's proposed index |
| pri_chg | output | 1 | Primary change strobe |
| pri_bad | output | 1 | Primary locked to an invalid reference |
| sec_sel | output | IDXW | Secondary selected reference index |
| sec_state | output | 2 | Secondary state: 0 locked, 1 holdover, 2 freerun, 3 tracking primary |
| sec_auto | output | IDXW | Secondary elector's proposed index |
| sec_chg | output | 1 | Secondary change strobe |
| sec_bad | output | 1 | Secondary locked to an invalid reference |

## Verification
The bench sweeps every valid mask against several priority patterns, including zero priorities and ties. It clears the references before each pattern so that every fresh election can be predicted. A wrong tie-break or a wrong handling of zero priority shows up as a wrong index, and a swapped fallback shows up as holdover where freerun was due. A separate sequence offers a better reference while one is locked; a revertive design would jump to it. Manual and hard-wired runs check the forced codes and index retention. They check that the switch takes exactly three edges, so a missing or extra synchronizer stage shows up as a mismatch, and that the strobe and the invalid flag rise and fall in the right cycle.

// File: rtl/refsel_pkg.sv
// Shared encodings for the reference selection controller.
// Assumes a 2-bit operating-state code and a 2-bit code kind field.
package refsel_pkg;
    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FREE  = 2'd2,
        ST_TRACK = 2'd3
    } opstate_t;

    localparam logic [1:0] KIND_REF  = 2'd0;
    localparam logic [1:0] KIND_HOLD = 2'd1;
    localparam logic [1:0] KIND_FREE = 2'd2;
    localparam logic [1:0] KIND_PEER = 2'd3;

    localparam logic [1:0] MODE_AUTO = 2'd0;
    localparam logic [1:0] MODE_MAN  = 2'd1;
    localparam logic [1:0] MODE_HW   = 2'd2;
endpackage

// File: rtl/refsel_sync2.sv
// Two-flop synchronizer for the asynchronous switch pin.
// Assumes the pin is quasi-static relative to clk; resets to 0.
module refsel_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta;

    // Shift the pin level through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            dout <= 1'b0;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/refsel_regs.sv
// Write-only configuration registers: two mode fields, two manual codes
// and the pair of hard-wired presets. Assumes DW >= 2*CW.
// Unused addresses are ignored.
module refsel_regs #(
    parameter int CW = 4,
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic [1:0]    p_mode,
    output logic [1:0]    s_mode,
    output logic [CW-1:0] p_code,
    output logic [CW-1:0] s_code,
    output logic [CW-1:0] pre_lo,
    output logic [CW-1:0] pre_hi
);
    import refsel_pkg::*;

    localparam logic [CW-1:0] CODE_FREE = {KIND_FREE, {(CW-2){1'b0}}};

    // Decode writes into the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_mode <= MODE_AUTO;
            s_mode <= MODE_AUTO;
            p_code <= CODE_FREE;
            s_code <= CODE_FREE;
            pre_lo <= '0;
            pre_hi <= '0;
        end else if (wr) begin
            case (addr)
                AW'(0): p_mode <= data[1:0];
                AW'(1): s_mode <= data[1:0];
                AW'(2): p_code <= data[CW-1:0];
                AW'(3): s_code <= data[CW-1:0];
                AW'(4): begin
                    pre_lo <= data[CW-1:0];
                    pre_hi <= data[2*CW-1:CW];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/refsel_elector.sv
// Non-revertive automatic elector. Locks to the eligible reference with
// the smallest nonzero priority (lowest index wins ties) and holds it until
// it becomes ineligible; otherwise falls back to holdover or freerun.
// Assumes the reset state is freerun on index 0.
module refsel_elector #(
    parameter int NREF = 4,
    parameter int PW   = 4,
    parameter int IDXW = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREF-1:0]           ref_valid,
    input  logic [NREF-1:0][PW-1:0]   prio,
    input  logic                      ho_avail,
    output logic [IDXW-1:0]           e_idx,
    output refsel_pkg::opstate_t      e_st
);
    import refsel_pkg::*;

    localparam int SPAN = 1 << IDXW;

    logic [NREF-1:0] elig;
    logic [SPAN-1:0] elig_ext;
    logic            found;
    logic [IDXW-1:0] best_i;
    logic [PW-1:0]   best_p;
    logic            keep;

    // Eligibility per reference
    genvar g;
    generate
        for (g = 0; g < NREF; g++) begin : g_elig
            assign elig[g] = ref_valid[g] && (prio[g] != '0);
        end
    endgenerate

    // Widen eligibility so any index value is a legal lookup
    always_comb begin
        elig_ext = '0;
        elig_ext[NREF-1:0] = elig;
    end

    // Search for the best eligible reference
    always_comb begin
        found  = 1'b0;
        best_i = '0;
        best_p = '1;
        for (int i = 0; i < NREF; i++) begin
            if (elig[i] && (!found || prio[i] < best_p)) begin
                found  = 1'b1;
                best_i = IDXW'(i);
                best_p = prio[i];
            end
        end
    end

    assign keep = (e_st == ST_LOCK) && elig_ext[e_idx];

    // Elector state update: hold, re-elect or fall back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_idx <= '0;
            e_st  <= ST_FREE;
        end else if (keep) begin
            e_idx <= e_idx;
            e_st  <= ST_LOCK;
        end else if (found) begin
            e_idx <= best_i;
            e_st  <= ST_LOCK;
        end else begin
            e_st  <= ho_avail ? ST_HOLD : ST_FREE;
        end
    end

    // R1: a still-eligible locked reference is never replaced
    p_nonrevert_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (e_st == ST_LOCK && elig_ext[e_idx]) |=> (e_st == ST_LOCK && e_idx == $past(e_idx)));

    // R3: fallback choice follows holdover history
    p_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> (e_st == ($past(ho_avail) ? ST_HOLD : ST_FREE)));

    // R4: any candidate brings the elector back to locked
    p_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |=> (e_st == ST_LOCK));
endmodule

// File: rtl/refsel_chan.sv
// One channel's output stage: resolves mode (automatic, manual or
// hard-wired) into a selected index and state, registers them, and
// produces the change strobe and the invalid-selection flag.
// Assumes the mode and code inputs come from registers and pin_s is
// already synchronized.
module refsel_chan #(
    parameter int NREF   = 4,
    parameter int IDXW   = 2,
    parameter int CW     = 4,
    parameter bit HAS_HW = 1'b1,
    parameter bit IS_SEC = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [CW-1:0]        man_code,
    input  logic [CW-1:0]        pre_lo,
    input  logic [CW-1:0]        pre_hi,
    input  logic                 pin_s,
    input  logic [IDXW-1:0]      e_idx,
    input  refsel_pkg::opstate_t e_st,
    input  logic [NREF-1:0]      ref_valid,
    output logic [IDXW-1:0]      o_sel,
    output refsel_pkg::opstate_t o_st,
    output logic                 o_chg,
    output logic                 o_bad
);
    import refsel_pkg::*;

    localparam int SPAN = 1 << IDXW;

    logic            is_auto;
    logic            is_hw;
    logic [CW-1:0]   code;
    logic [1:0]      kind;
    logic [IDXW-1:0] n_sel;
    opstate_t        n_st;
    logic            n_bad;
    logic [SPAN-1:0] valid_ext;

    // Classify the channel mode
    always_comb begin
        is_auto = (mode == MODE_AUTO) || (mode == 2'd3);
        is_hw   = HAS_HW && (mode == MODE_HW);
    end

    // Pick the active code: register or pin-selected preset
    always_comb begin
        code = is_hw ? (pin_s ? pre_hi : pre_lo) : man_code;
        kind = code[CW-1:CW-2];
    end

    // Resolve next selection and state
    always_comb begin
        n_sel = o_sel;
        n_st  = o_st;
        if (is_auto) begin
            n_sel = e_idx;
            n_st  = e_st;
        end else begin
            case (kind)
                KIND_REF: begin
                    n_sel = code[IDXW-1:0];
                    n_st  = ST_LOCK;
                end
                KIND_HOLD: n_st = ST_HOLD;
                KIND_FREE: n_st = ST_FREE;
                default: begin
                    if (IS_SEC) begin
                        n_sel = '0;
                        n_st  = ST_TRACK;
                    end else begin
                        n_st  = ST_FREE;
                    end
                end
            endcase
        end
    end

    // Validity of the selection being made
    always_comb begin
        valid_ext = '0;
        valid_ext[NREF-1:0] = ref_valid;
        n_bad = (n_st == ST_LOCK) && !valid_ext[n_sel];
    end

    // Register outputs and flag changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_sel <= '0;
            o_st  <= ST_FREE;
            o_chg <= 1'b0;
            o_bad <= 1'b0;
        end else begin
            o_sel <= n_sel;
            o_st  <= n_st;
            o_chg <= (n_sel != o_sel) || (n_st != o_st);
            o_bad <= n_bad;
        end
    end

    // R5: automatic mode mirrors the elector one edge later
    p_auto_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO) |=> (o_sel == $past(e_idx) && o_st == $past(e_st)));

    // R10: every output change carries the strobe
    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_sel != $past(o_sel) || o_st != $past(o_st)) |-> o_chg);

    // R10: the strobe is never raised without a change
    p_strobe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_sel == $past(o_sel) && o_st == $past(o_st)) |-> !o_chg);

    // R12: a forced holdover keeps the previous index
    p_hold_idx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MAN && man_code[CW-1:CW-2] == KIND_HOLD) |=> (o_sel == $past(o_sel)));
endmodule

// File: rtl/ref_select_ctrl.sv
// Top of the reference selection controller: configuration registers,
// one elector per channel, the switch-pin synchronizer and two channel
// output stages (hard-wired mode on the primary only).
// Assumes ref_valid and ref_prio are synchronous to clk.
module ref_select_ctrl #(
    parameter int NREF = 4,
    parameter int PW   = 4,
    parameter int DW   = 8,
    parameter int AW   = 3,
    localparam int IDXW = (NREF > 1) ? $clog2(NREF) : 1,
    localparam int CW   = IDXW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREF-1:0]    ref_valid,
    input  logic [NREF*PW-1:0] ref_prio,
    input  logic               ho_avail,
    input  logic               cfg_wr,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [DW-1:0]      cfg_data,
    input  logic               sw_pin,
    output logic [IDXW-1:0]    pri_sel,
    output logic [1:0]         pri_state,
    output logic [IDXW-1:0]    pri_auto,
    output logic               pri_chg,
    output logic               pri_bad,
    output logic [IDXW-1:0]    sec_sel,
    output logic [1:0]         sec_state,
    output logic [IDXW-1:0]    sec_auto,
    output logic               sec_chg,
    output logic               sec_bad
);
    import refsel_pkg::*;

    localparam int NCH = 2;

    logic [NREF-1:0][PW-1:0] prio;
    logic [1:0]              mode   [NCH];
    logic [CW-1:0]           mcode  [NCH];
    logic [CW-1:0]           pre_lo;
    logic [CW-1:0]           pre_hi;
    logic                    pin_s;
    logic [IDXW-1:0]         e_idx  [NCH];
    opstate_t                e_st   [NCH];
    logic [IDXW-1:0]         o_sel  [NCH];
    opstate_t                o_st   [NCH];
    logic                    o_chg  [NCH];
    logic                    o_bad  [NCH];

    assign prio = ref_prio;

    refsel_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .addr   (cfg_addr),
        .data   (cfg_data),
        .p_mode (mode[0]),
        .s_mode (mode[1]),
        .p_code (mcode[0]),
        .s_code (mcode[1]),
        .pre_lo (pre_lo),
        .pre_hi (pre_hi)
    );

    refsel_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sw_pin),
        .dout  (pin_s)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            refsel_elector #(.NREF(NREF), .PW(PW), .IDXW(IDXW)) u_elect (
                .clk       (clk),
                .rst_n     (rst_n),
                .ref_valid (ref_valid),
                .prio      (prio),
                .ho_avail  (ho_avail),
                .e_idx     (e_idx[c]),
                .e_st      (e_st[c])
            );

            refsel_chan #(
                .NREF   (NREF),
                .IDXW   (IDXW),
                .CW     (CW),
                .HAS_HW (c == 0),
                .IS_SEC (c == 1)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode      (mode[c]),
                .man_code  (mcode[c]),
                .pre_lo    (pre_lo),
                .pre_hi    (pre_hi),
                .pin_s     (pin_s),
                .e_idx     (e_idx[c]),
                .e_st      (e_st[c]),
                .ref_valid (ref_valid),
                .o_sel     (o_sel[c]),
                .o_st      (o_st[c]),
                .o_chg     (o_chg[c]),
                .o_bad     (o_bad[c])
            );
        end
    endgenerate

    // Map channel results onto the ports
    always_comb begin
        pri_sel   = o_sel[0];
        pri_state = o_st[0];
        pri_auto  = e_idx[0];
        pri_chg   = o_chg[0];
        pri_bad   = o_bad[0];
        sec_sel   = o_sel[1];
        sec_state = o_st[1];
        sec_auto  = e_idx[1];
        sec_chg   = o_chg[1];
        sec_bad   = o_bad[1];
    end

    // R8: the primary channel never reports the tracking state
    p_pri_no_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pri_state != 2'd3);
endmodule

// File: tb/ref_select_ctrl_test.sv
`timescale 1ns/1ps
module ref_select_ctrl_test;
    localparam int NREF = 4;
    localparam int PW   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NREF-1:0]  ref_valid = '0;
    logic [NREF*PW-1:0] ref_prio = '0;
    logic             ho_avail = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [7:0]       cfg_data = '0;
    logic             sw_pin = 1'b0;
    logic [1:0]       pri_sel, pri_auto, sec_sel, sec_auto;
    logic [1:0]       pri_state, sec_state;
    logic             pri_chg, pri_bad, sec_chg, sec_bad;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ref_select_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_prio(ref_prio),
        .ho_avail(ho_avail), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .sw_pin(sw_pin),
        .pri_sel(pri_sel), .pri_state(pri_state), .pri_auto(pri_auto),
        .pri_chg(pri_chg), .pri_bad(pri_bad),
        .sec_sel(sec_sel), .sec_state(sec_state), .sec_auto(sec_auto),
        .sec_chg(sec_chg), .sec_bad(sec_bad)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_data = 8'(d);
        tick(1);
        cfg_wr = 1'b0;
    endtask

    function automatic int prio_of(input int i, input int p);
        return (i * (p + 1) + p) % 3;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_idx, exp_st, old_idx, old_st;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R6 reset state: automatic, freerun on index 0
        check("R6 reset state", pri_state, 2);
        check("R6 reset sel", pri_sel, 0);
        check("R10 reset strobe", pri_chg, 0);
        check("R11 reset bad", pri_bad, 0);
        exp_idx = 0; exp_st = 2;

        // Sweep every valid mask against several priority patterns
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                int h, best, bp;
                h = (p ^ (m >> 1)) & 1;
                ref_valid = '0; ho_avail = h[0];
                tick(2);
                exp_st = h ? 1 : 2;
                check("R3 fallback state", pri_state, exp_st);
                check("R12 fallback keeps index", pri_sel, exp_idx);
                old_idx = exp_idx; old_st = exp_st;
                for (int i = 0; i < NREF; i++) ref_prio[i*PW +: PW] = PW'(prio_of(i, p));
                ref_valid = 4'(m);
                tick(2);
                best = -1; bp = 99;
                for (int i = 0; i < NREF; i++)
                    if (m[i] && prio_of(i, p) != 0 && prio_of(i, p) < bp) begin
                        best = i; bp = prio_of(i, p);
                    end
                if (best >= 0) begin exp_idx = best; exp_st = 0; end
                check("R2 R4 elected state", pri_state, exp_st);
                check("R2 elected index", pri_sel, exp_idx);
                check("R5 auto readback", pri_auto, exp_idx);
                check("R5 secondary auto", sec_sel, exp_idx);
                check("R10 strobe on change", pri_chg,
                      (old_idx != exp_idx || old_st != exp_st) ? 1 : 0);
                tick(1);
                check("R10 strobe one cycle", pri_chg, 0);
            end
        end

        // R1 non-revertive: better candidate does not pre-empt
        ref_valid = '0; tick(2);
        ref_prio = {4'd1, 4'd3, 4'd2, 4'd1};
        ref_valid = 4'b0100; tick(2);
        check("R1 locked to 2", pri_sel, 2);
        ref_valid = 4'b0101; tick(2);
        check("R1 stays on 2", pri_sel, 2);
        check("R1 stays locked", pri_state, 0);
        ref_valid = 4'b0001; tick(2);
        check("R1 re-elects after loss", pri_sel, 0);

        // Manual mode on an invalid reference
        wr(2, 8'b0011); wr(0, 1); tick(1);
        check("R7 manual sel", pri_sel, 3);
        check("R7 manual state", pri_state, 0);
        check("R11 invalid flag", pri_bad, 1);
        check("R5 auto readback in manual", pri_auto, 0);
        ref_valid = 4'b1001; tick(1);
        check("R11 flag clears", pri_bad, 0);
        wr(2, 8'b0100); tick(1);
        check("R7 forced holdover", pri_state, 1);
        check("R12 holdover keeps index", pri_sel, 3);
        wr(2, 8'b1000); tick(1);
        check("R7 forced freerun", pri_state, 2);
        wr(2, 8'b0001); tick(1);
        check("R7 manual sel 1", pri_sel, 1);
        wr(2, 8'b1100); tick(1);
        check("R8 primary kind 3 freerun", pri_state, 2);
        check("R12 freerun keeps index", pri_sel, 1);

        // Secondary tracks primary
        wr(3, 8'b1100); wr(1, 1); tick(1);
        check("R8 secondary tracking", sec_state, 3);
        check("R8 tracking index", sec_sel, 0);
        // Secondary mode 2 behaves as manual
        wr(4, 8'h42); wr(3, 8'b0001); wr(1, 2); tick(1);
        check("R9 secondary mode 2 manual", sec_sel, 1);
        check("R9 secondary mode 2 state", sec_state, 0);

        // Hard-wired switching on the primary
        wr(0, 2); tick(1);
        check("R9 pin low preset", pri_sel, 2);
        check("R9 pin low state", pri_state, 0);
        sw_pin = 1'b1; tick(2);
        check("R9 not before third edge", pri_state, 0);
        tick(1);
        check("R9 pin high preset", pri_state, 1);
        check("R12 preset holdover index", pri_sel, 2);
        check("R10 strobe on switch", pri_chg, 1);
        tick(1);
        check("R10 strobe drops", pri_chg, 0);
        sw_pin = 1'b0; tick(3);
        check("R9 pin back low", pri_state, 0);

        // Return to automatic
        wr(0, 0); tick(1);
        check("R6 back to automatic", pri_sel, 0);
        check("R6 automatic state", pri_state, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule